// File: doc/BRIEF.md
# Integer Execute Unit with Decoder

This block decodes a 32-bit instruction word and performs one integer operation from a small subset. The decoded register indices leave the block at once, so that a register file can return the two 64-bit operands in the same cycle. The unit then computes the result and registers it together with a write strobe, the destination index and an illegal-instruction flag. All four appear at the outputs on the next rising clock edge.

The subset has these operations:
- a 64-bit add;
- two 32-bit adds, one that sign-extends the sum and one that zero-extends it;
- AND, and AND with the complement of the right operand;
- three compares that produce 0 or 1;
- two conditional moves that test the left operand against zero;
- a full eight-byte reverse;
- three forms that take a signed 10-bit immediate: add, 32-bit add and AND.

Any other encoding is flagged as illegal and writes nothing.

Top module: `ixu_top`

## Requirements
- R1: The index outputs come straight from the instruction word, with no clock in between: `rm_idx` = instr[25:20], `rn_idx` = instr[15:10], `rd_idx` = instr[9:4]. Bits 31:26 hold the major opcode and bits 19:16 hold the minor opcode. `wr_idx` is the `rd_idx` value captured at the clock edge.
- R2: Major 0 with minor 9 writes the 64-bit sum opa+opb. The sum appears at `result` one clock edge after the instruction is presented, with `wr_en`=1.
- R3: Major 0 with minor 8 adds the low 32 bits of opa and opb and sign-extends the 32-bit sum to 64 bits. Minor 12 does the same add and zero-extends the sum. The upper operand halves have no effect in either case.
- R4: Major 0 with minors 1, 3 and 7 compare opa against opb. Minor 1 tests equal, minor 3 tests signed greater-than and minor 7 tests unsigned greater-than. Each writes 1 when the condition holds and 0 when it does not.
- R5: Major 0 with minor 15 and instr[15:10]=63 writes opa with its eight bytes in reverse order. With any other value in instr[15:10] the same encoding is illegal.
- R6: Major 1 with minor 11 writes opa AND opb. Minor 15 writes opa AND NOT opb.
- R7: Major 8 with minor 1 writes opb only when opa is zero. Minor 5 writes opb only when opa is nonzero. When the condition fails, `wr_en` is 0 and `illegal` is 0.
- R8: Majors 52, 53 and 54 take a signed 10-bit immediate from instr[19:10]. Major 52 writes opa plus the sign-extended immediate. Major 53 adds the immediate to the low 32 bits of opa and sign-extends the 32-bit sum. Major 54 writes opa AND the sign-extended immediate.
- R9: Any encoding outside R2 to R8, or any instruction with instr[3:0] nonzero, gives `illegal`=1 and `wr_en`=0 after the clock edge.
- R10: While `rst_n` is low, `wr_en`, `illegal`, `wr_idx` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word |
| opa | input | 64 | Operand read at `rm_idx` |
| opb | input | 64 | Operand read at `rn_idx` |
| rm_idx | output | 6 | Left register index |
| rn_idx | output | 6 | Right register index |
| rd_idx | output | 6 | Destination register index |
| result | output | 64 | Registered result |
| wr_en | output | 1 | Registered write strobe |
| wr_idx | output | 6 | Registered destination index |
| illegal | output | 1 | Registered illegal-instruction flag |

## Verification
On every cycle the assertions check four things:
- a nonzero reserved field always produces the illegal flag and no write;
- the illegal flag and the write strobe are never set together;
- compares leave only bit 0 of the result able to be set, and the zero-extending add leaves the upper half clear;
- a conditional move writes only when its zero test on the captured operand holds.

The arithmetic values can be shown only by the bench's scenarios:
- carries across the 32-bit boundary;
- signed against unsigned ordering;
- the exact byte order of the reverse;
- the sign extension of the immediate at its two extremes.

The same goes for reset taking hold in the middle of a run and for the byte reverse that is rejected because of its right-register field.

// File: rtl/ixu_pkg.sv
package ixu_pkg;
  localparam int unsigned IW   = 32;
  localparam int unsigned RIW  = 6;
  localparam int unsigned MAJW = 6;
  localparam int unsigned MINW = 4;
  localparam int unsigned IMMW = 10;

  typedef enum logic [3:0] {
    K_ADD, K_ADD32S, K_ADD32Z, K_CEQ, K_CGT, K_CGTU, K_BREV,
    K_AND, K_ANDN, K_MVZ, K_MVNZ, K_ADDI, K_ADDI32, K_ANDI, K_BAD
  } kind_e;

  localparam logic [MAJW-1:0] MAJ_REG   = 6'd0;
  localparam logic [MAJW-1:0] MAJ_LOGIC = 6'd1;
  localparam logic [MAJW-1:0] MAJ_CMOV  = 6'd8;
  localparam logic [MAJW-1:0] MAJ_ADDI  = 6'd52;
  localparam logic [MAJW-1:0] MAJ_ADDIW = 6'd53;
  localparam logic [MAJW-1:0] MAJ_ANDI  = 6'd54;
endpackage

// File: rtl/ixu_decode.sv
module ixu_decode
  import ixu_pkg::*;
(
  input  logic [IW-1:0]   instr,
  output logic [RIW-1:0]  rm,
  output logic [RIW-1:0]  rn,
  output logic [RIW-1:0]  rd,
  output logic [IMMW-1:0] imm,
  output kind_e           kind
);
  logic [MAJW-1:0] maj;
  logic [MINW-1:0] mnr;
  logic            rsvd_ok;

  assign maj     = instr[31:26];
  assign rm      = instr[25:20];
  assign mnr     = instr[19:16];
  assign rn      = instr[15:10];
  assign rd      = instr[9:4];
  assign imm     = instr[19:10];
  assign rsvd_ok = (instr[3:0] == 4'd0);

  always_comb begin
    kind = K_BAD;
    unique case (maj)
      MAJ_REG: begin
        case (mnr)
          4'd9:  kind = K_ADD;
          4'd8:  kind = K_ADD32S;
          4'd12: kind = K_ADD32Z;
          4'd1:  kind = K_CEQ;
          4'd3:  kind = K_CGT;
          4'd7:  kind = K_CGTU;
          4'd15: kind = (rn == '1) ? K_BREV : K_BAD;
          default: kind = K_BAD;
        endcase
      end
      MAJ_LOGIC: begin
        case (mnr)
          4'd11: kind = K_AND;
          4'd15: kind = K_ANDN;
          default: kind = K_BAD;
        endcase
      end
      MAJ_CMOV: begin
        case (mnr)
          4'd1: kind = K_MVZ;
          4'd5: kind = K_MVNZ;
          default: kind = K_BAD;
        endcase
      end
      MAJ_ADDI:  kind = K_ADDI;
      MAJ_ADDIW: kind = K_ADDI32;
      MAJ_ANDI:  kind = K_ANDI;
      default:   kind = K_BAD;
    endcase
    if (!rsvd_ok) kind = K_BAD;
  end
endmodule

// File: rtl/ixu_alu.sv
module ixu_alu
  import ixu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  kind_e            kind,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [IMMW-1:0]  imm,
  output logic [XLEN-1:0]  res,
  output logic             wr
);
  localparam int unsigned HW    = XLEN / 2;
  localparam int unsigned NBYTE = XLEN / 8;

  logic [XLEN-1:0] simm;
  logic [HW-1:0]   sum_w;
  logic [HW-1:0]   sum_wi;
  logic [XLEN-1:0] rev;

  assign simm   = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  assign sum_w  = a[HW-1:0] + b[HW-1:0];
  assign sum_wi = a[HW-1:0] + simm[HW-1:0];

  for (genvar g = 0; g < NBYTE; g++) begin : g_rev
    assign rev[8*g +: 8] = a[8*(NBYTE-1-g) +: 8];
  end

  always_comb begin
    res = '0;
    wr  = 1'b1;
    unique case (kind)
      K_ADD:    res = a + b;
      K_ADD32S: res = {{HW{sum_w[HW-1]}}, sum_w};
      K_ADD32Z: res = {{HW{1'b0}}, sum_w};
      K_CEQ:    res = {{(XLEN-1){1'b0}}, (a == b)};
      K_CGT:    res = {{(XLEN-1){1'b0}}, ($signed(a) > $signed(b))};
      K_CGTU:   res = {{(XLEN-1){1'b0}}, (a > b)};
      K_BREV:   res = rev;
      K_AND:    res = a & b;
      K_ANDN:   res = a & ~b;
      K_MVZ:  begin res = b; wr = (a == '0); end
      K_MVNZ: begin res = b; wr = (a != '0); end
      K_ADDI:   res = a + simm;
      K_ADDI32: res = {{HW{sum_wi[HW-1]}}, sum_wi};
      K_ANDI:   res = a & simm;
      default: begin res = '0; wr = 1'b0; end
    endcase
  end
endmodule

// File: rtl/ixu_top.sv
module ixu_top
  import ixu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    instr,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  output logic [RIW-1:0]   rm_idx,
  output logic [RIW-1:0]   rn_idx,
  output logic [RIW-1:0]   rd_idx,
  output logic [XLEN-1:0]  result,
  output logic             wr_en,
  output logic [RIW-1:0]   wr_idx,
  output logic             illegal
);
  localparam int unsigned HW = XLEN / 2;

  kind_e           kind;
  logic [IMMW-1:0] imm;
  logic [XLEN-1:0] alu_res;
  logic            alu_wr;
  logic            wr_d, ill_d;
  logic [XLEN-1:0] result_q;
  logic            wr_q, ill_q, seen_q;
  logic [RIW-1:0]  wr_idx_q;

  ixu_decode u_dec (
    .instr(instr), .rm(rm_idx), .rn(rn_idx), .rd(rd_idx), .imm(imm), .kind(kind)
  );

  ixu_alu #(.XLEN(XLEN)) u_alu (
    .kind(kind), .a(opa), .b(opb), .imm(imm), .res(alu_res), .wr(alu_wr)
  );

  always_comb begin
    ill_d = (kind == K_BAD);
    wr_d  = alu_wr && !ill_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      wr_q     <= 1'b0;
      ill_q    <= 1'b0;
      wr_idx_q <= '0;
      seen_q   <= 1'b0;
    end else begin
      wr_q     <= wr_d;
      ill_q    <= ill_d;
      wr_idx_q <= rd_idx;
      seen_q   <= 1'b1;
      if (wr_d) result_q <= alu_res;
    end
  end

  assign result  = result_q;
  assign wr_en   = wr_q;
  assign wr_idx  = wr_idx_q;
  assign illegal = ill_q;

  // R9
  rsvd_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(instr[3:0] != 4'd0) |-> (illegal && !wr_en));
  // R9
  ill_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_en);
  // R4
  cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(kind == K_CEQ || kind == K_CGT || kind == K_CGTU)
    |-> (result[XLEN-1:1] == '0 && wr_en));
  // R3
  zext_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(kind == K_ADD32Z) |-> (result[XLEN-1:HW] == '0));
  // R7
  cmov_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(kind == K_MVZ) |-> (wr_en == $past(opa == '0)));
  // R7
  cmov_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(kind == K_MVNZ) |-> (wr_en == $past(opa != '0)));
endmodule

// File: tb/ixu_top_tb.sv
module ixu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] opa = '0, opb = '0;
  logic [5:0]  rm_idx, rn_idx, rd_idx, wr_idx;
  logic [63:0] result;
  logic        wr_en, illegal;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ixu_top u_dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .opa(opa), .opb(opb),
    .rm_idx(rm_idx), .rn_idx(rn_idx), .rd_idx(rd_idx),
    .result(result), .wr_en(wr_en), .wr_idx(wr_idx), .illegal(illegal)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [5:0]  maj;
    logic [3:0]  mnr;
    logic [5:0]  rnf;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
    logic        we;
    logic        ill;
  } vec_t;

  localparam logic [63:0] VA = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] VB = 64'h0000_0001_7654_3211;
  localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{"R2 ", 6'd0, 4'd9,  6'd2,  VA, VB, 64'h0123_4569_0000_0000, 1'b1, 1'b0},
    '{"R3 ", 6'd0, 4'd8,  6'd2,  64'hFFFF_0000_7FFF_FFFF, 64'h1234_0000_0000_0001, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0},
    '{"R3 ", 6'd0, 4'd12, 6'd2,  64'hFFFF_0000_7FFF_FFFF, 64'h1234_0000_0000_0001, 64'h0000_0000_8000_0000, 1'b1, 1'b0},
    '{"R4 ", 6'd0, 4'd1,  6'd2,  64'd5, 64'd5, 64'd1, 1'b1, 1'b0},
    '{"R4 ", 6'd0, 4'd1,  6'd2,  64'd5, 64'd6, 64'd0, 1'b1, 1'b0},
    '{"R4 ", 6'd0, 4'd3,  6'd2,  M1, 64'd1, 64'd0, 1'b1, 1'b0},
    '{"R4 ", 6'd0, 4'd3,  6'd2,  64'd1, M1, 64'd1, 1'b1, 1'b0},
    '{"R4 ", 6'd0, 4'd7,  6'd2,  M1, 64'd1, 64'd1, 1'b1, 1'b0},
    '{"R5 ", 6'd0, 4'd15, 6'd63, VA, VB, 64'hEFCD_AB89_6745_2301, 1'b1, 1'b0},
    '{"R5 ", 6'd0, 4'd15, 6'd5,  VA, VB, 64'd0, 1'b0, 1'b1},
    '{"R6 ", 6'd1, 4'd11, 6'd2,  VA, VB, 64'h0000_0001_0000_0001, 1'b1, 1'b0},
    '{"R6 ", 6'd1, 4'd15, 6'd2,  VA, VB, 64'h0123_4566_89AB_CDEE, 1'b1, 1'b0},
    '{"R7 ", 6'd8, 4'd1,  6'd2,  64'd0, VB, VB, 1'b1, 1'b0},
    '{"R7 ", 6'd8, 4'd1,  6'd2,  64'd1, VA, 64'd0, 1'b0, 1'b0},
    '{"R7 ", 6'd8, 4'd5,  6'd2,  64'd1, VA, VA, 1'b1, 1'b0},
    '{"R7 ", 6'd8, 4'd5,  6'd2,  64'd0, VB, 64'd0, 1'b0, 1'b0},
    '{"R8 ", 6'd52, 4'hF, 6'h3F, 64'h10, 64'd0, 64'hF, 1'b1, 1'b0},
    '{"R8 ", 6'd52, 4'h7, 6'h3F, 64'h1, 64'd0, 64'h200, 1'b1, 1'b0},
    '{"R8 ", 6'd53, 4'h0, 6'h01, 64'hFFFF_FFFF_7FFF_FFFF, 64'd0, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0},
    '{"R8 ", 6'd54, 4'h8, 6'h00, VA, 64'd0, 64'h0123_4567_89AB_CC00, 1'b1, 1'b0},
    '{"R9 ", 6'd2, 4'd9,  6'd2,  VA, VB, 64'd0, 1'b0, 1'b1},
    '{"R9 ", 6'd0, 4'd0,  6'd2,  VA, VB, 64'd0, 1'b0, 1'b1},
    '{"R9 ", 6'd1, 4'd9,  6'd2,  VA, VB, 64'd0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b);
    instr = w; opa = a; opb = b;
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #7;
    // R10 reset state
    chk("R10", {61'd0, wr_en, illegal, wr_idx != 0}, 64'd0);
    chk("R10", result, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R1 combinational index decode
    instr = {6'd0, 6'd21, 4'd9, 6'd42, 6'd13, 4'd0}; #1;
    chk("R1", {46'd0, rm_idx, rn_idx, rd_idx}, {46'd0, 6'd21, 6'd42, 6'd13});
    @(posedge clk); #1;
    chk("R1", {58'd0, wr_idx}, 64'd13);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      @(negedge clk);
      issue({v.maj, 6'd3, v.mnr, v.rnf, 6'd7, 4'd0}, v.a, v.b);
      chk(string'(v.tag), {62'd0, wr_en, illegal}, {62'd0, v.we, v.ill});
      if (v.we) chk(string'(v.tag), result, v.exp);
    end

    // R7 no write leaves previous result in place
    @(negedge clk); issue({6'd0, 6'd3, 4'd9, 6'd4, 6'd7, 4'd0}, 64'd40, 64'd2);
    chk("R2", result, 64'd42);
    @(negedge clk); issue({6'd8, 6'd3, 4'd1, 6'd4, 6'd7, 4'd0}, 64'd9, 64'd77);
    chk("R7", {63'd0, wr_en}, 64'd0);
    chk("R7", result, 64'd42);

    // R9 nonzero reserved bits on an otherwise legal add
    @(negedge clk); issue({6'd0, 6'd3, 4'd9, 6'd4, 6'd7, 4'd4}, 64'd1, 64'd1);
    chk("R9", {62'd0, wr_en, illegal}, 64'd1);

    // R10 reset in mid-run
    @(negedge clk); issue({6'd0, 6'd3, 4'd9, 6'd4, 6'd7, 4'd0}, 64'd5, 64'd5);
    chk("R2", result, 64'd10);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R10", {61'd0, wr_en, illegal, wr_idx != 0}, 64'd0);
    chk("R10", result, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule